// File: doc/BRIEF.md
# Reorder Buffer With In-Order Commit

This block tracks in-flight instructions for a pipeline that issues in order, finishes out of order and commits at the end of the pipeline. The decode stage claims one slot per cycle at the tail of a circular queue and receives the slot index. The instruction carries that index down the pipeline. At writeback it marks its own slot as finished, in whatever order results arrive. The commit stage looks only at the oldest slot. Once that slot has finished, the block retires it, frees it, and, when the instruction writes a register, raises a write strobe with the register number. The register files use that strobe to copy the committed value from the working file into the architectural file.

A writeback may also report a fault for its slot. When the oldest slot has finished with a fault, the block raises a one-cycle flush instead of retiring. On the following edge it drops every in-flight slot and returns both queue pointers to slot zero. A restore-busy output then stays high for a configurable number of cycles so that the register files can copy their state back. No new slots are handed out while restore-busy is high.

Top module: `rob_commit_queue`

## Requirements
- R1: After a synchronous reset the queue reports empty=1 and full=0, and retire_vld, retire_wr, flush_out and restore_busy are all 0.
- R2: alloc_idx always shows the tail slot. alloc_gnt equals alloc_req when the queue is not full, restore_busy is 0 and flush_out is 0. Each grant moves the tail to the next slot, modulo ENTRIES.
- R3: After ENTRIES grants with no retirement, full=1. While full, alloc_gnt is 0 and the tail index stays the same.
- R4: Writebacks may mark slots in any order. A finished younger slot is not retired while the oldest slot is still pending.
- R5: Slots retire in allocation order. retire_vld is 1 in the cycle after the oldest slot's completion is accepted (it is combinational from registered state). retire_idx names that slot and retire_dst_reg gives its destination. retire_wr is 1 only when the slot was allocated with alloc_dst_vld=1.
- R6: Once every allocated slot has retired, empty=1 and retire_vld=0.
- R7: A completion that names a slot not currently allocated has no effect. A later allocation of that slot still waits for its own completion.
- R8: A grant, a completion and a retirement can all take effect in the same cycle.
- R9: When the oldest slot has finished with a fault, flush_out is 1 for that cycle, retire_vld and alloc_gnt are 0, and after the next edge empty=1 and alloc_idx=0.
- R10: After a flush, restore_busy is 1 for exactly RESTORE_CYC cycles, and alloc_gnt stays 0 during those cycles.
- R11: Younger slots that had already finished before a flush never retire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_req | input | 1 | Decode asks for a slot |
| alloc_dst_vld | input | 1 | The instruction writes a register |
| alloc_dst_reg | input | 5 | Destination register number |
| alloc_gnt | output | 1 | Slot granted this cycle |
| alloc_idx | output | IDX_W | Tail slot index given to decode |
| cmpl_vld | input | 1 | Writeback marks a slot finished |
| cmpl_idx | input | IDX_W | Slot being marked |
| cmpl_fault | input | 1 | The finishing instruction faulted |
| retire_vld | output | 1 | The oldest slot retires this cycle |
| retire_idx | output | IDX_W | Index of the oldest slot |
| retire_wr | output | 1 | Copy the committed value to the architectural file |
| retire_dst_reg | output | 5 | Register being committed |
| flush_out | output | 1 | Fault at commit; all slots are dropped at the edge |
| restore_busy | output | 1 | Register-file restore in progress |
| full | output | 1 | No free slot |
| empty | output | 1 | No slot in flight |

## Verification
The checker assumes that writeback names only slots in flight and marks each slot once, and that a fault is reported only together with a completion. Under those assumptions, retirement indices advance by one and grants never overlap a full or restoring queue. The stimulus completes only indices it has already been granted, with one exception. That exception is a single completion sent on purpose to a free slot, to show that such a completion is ignored. No slot is ever marked twice.

// File: rtl/rob_pkg.sv
package rob_pkg;

    localparam int ROB_REG_W = 5;

    typedef struct packed {
        logic                 valid;
        logic                 pending;
        logic                 fault;
        logic                 dst_vld;
        logic [ROB_REG_W-1:0] dst_reg;
    } rob_entry_t;

    typedef enum logic [1:0] {
        HEAD_IDLE   = 2'd0,
        HEAD_WAIT   = 2'd1,
        HEAD_RETIRE = 2'd2,
        HEAD_FAULT  = 2'd3
    } head_state_e;

    function automatic head_state_e rob_classify(input rob_entry_t e);
        if (!e.valid)       return HEAD_IDLE;
        else if (e.pending) return HEAD_WAIT;
        else if (e.fault)   return HEAD_FAULT;
        else                return HEAD_RETIRE;
    endfunction

endpackage

// File: rtl/rob_ptr_ctrl.sv
module rob_ptr_ctrl #(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             adv_tail,
    input  logic             adv_head,
    output logic [IDX_W-1:0] head_idx,
    output logic [IDX_W-1:0] tail_idx,
    output logic             full,
    output logic             empty
);
    localparam int PW = IDX_W + 1;

    logic [PW-1:0] head_q, tail_q;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            head_q <= '0;
            tail_q <= '0;
        end else begin
            if (adv_tail) tail_q <= tail_q + PW'(1);
            if (adv_head) head_q <= head_q + PW'(1);
        end
    end

    assign head_idx = head_q[IDX_W-1:0];
    assign tail_idx = tail_q[IDX_W-1:0];
    assign empty    = (head_q == tail_q);
    assign full     = (head_q[IDX_W] != tail_q[IDX_W]) &&
                      (head_q[IDX_W-1:0] == tail_q[IDX_W-1:0]);
endmodule

// File: rtl/rob_entry_array.sv
module rob_entry_array
    import rob_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 flush,
    input  logic                 alloc_en,
    input  logic [IDX_W-1:0]     alloc_idx,
    input  logic                 alloc_dst_vld,
    input  logic [ROB_REG_W-1:0] alloc_dst_reg,
    input  logic                 cmpl_en,
    input  logic [IDX_W-1:0]     cmpl_idx,
    input  logic                 cmpl_fault,
    input  logic                 free_en,
    input  logic [IDX_W-1:0]     free_idx,
    output rob_entry_t           ent_o [ENTRIES]
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
        rob_entry_t slot_q;

        always_ff @(posedge clk) begin
            if (rst || flush) begin
                slot_q <= '0;
            end else if (alloc_en && alloc_idx == MY_IDX) begin
                slot_q.valid   <= 1'b1;
                slot_q.pending <= 1'b1;
                slot_q.fault   <= 1'b0;
                slot_q.dst_vld <= alloc_dst_vld;
                slot_q.dst_reg <= alloc_dst_reg;
            end else begin
                if (cmpl_en && cmpl_idx == MY_IDX && slot_q.valid) begin
                    slot_q.pending <= 1'b0;
                    slot_q.fault   <= cmpl_fault;
                end
                if (free_en && free_idx == MY_IDX) begin
                    slot_q.valid <= 1'b0;
                end
            end
        end

        assign ent_o[g] = slot_q;
    end
endmodule

// File: rtl/rob_restore_timer.sv
module rob_restore_timer #(
    parameter int RESTORE_CYC = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    if (RESTORE_CYC == 0) begin : g_none
        logic unused_in;
        assign unused_in = clk ^ rst ^ start;
        assign busy      = 1'b0;
    end else begin : g_count
        localparam int CW = $clog2(RESTORE_CYC + 1);
        logic [CW-1:0] cnt_q;

        always_ff @(posedge clk) begin
            if (rst)                cnt_q <= '0;
            else if (start)         cnt_q <= CW'(RESTORE_CYC);
            else if (cnt_q != '0)   cnt_q <= cnt_q - CW'(1);
        end

        assign busy = (cnt_q != '0);
    end
endmodule

// File: rtl/rob_commit_queue.sv
module rob_commit_queue
    import rob_pkg::*;
#(
    parameter int  ENTRIES     = 8,
    parameter int  RESTORE_CYC = 3,
    localparam int IDX_W       = $clog2(ENTRIES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 alloc_req,
    input  logic                 alloc_dst_vld,
    input  logic [ROB_REG_W-1:0] alloc_dst_reg,
    output logic                 alloc_gnt,
    output logic [IDX_W-1:0]     alloc_idx,
    input  logic                 cmpl_vld,
    input  logic [IDX_W-1:0]     cmpl_idx,
    input  logic                 cmpl_fault,
    output logic                 retire_vld,
    output logic [IDX_W-1:0]     retire_idx,
    output logic                 retire_wr,
    output logic [ROB_REG_W-1:0] retire_dst_reg,
    output logic                 flush_out,
    output logic                 restore_busy,
    output logic                 full,
    output logic                 empty
);
    logic [IDX_W-1:0] head_idx, tail_idx;
    rob_entry_t       ents [ENTRIES];
    rob_entry_t       head_e;
    head_state_e      head_st;

    assign head_e  = ents[head_idx];
    assign head_st = rob_classify(head_e);

    assign retire_vld     = (head_st == HEAD_RETIRE);
    assign flush_out      = (head_st == HEAD_FAULT);
    assign retire_idx     = head_idx;
    assign retire_wr      = retire_vld && head_e.dst_vld;
    assign retire_dst_reg = head_e.dst_reg;

    assign alloc_idx = tail_idx;
    assign alloc_gnt = alloc_req && !full && !restore_busy && !flush_out;

    rob_ptr_ctrl #(.IDX_W(IDX_W)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush_out),
        .adv_tail (alloc_gnt),
        .adv_head (retire_vld),
        .head_idx (head_idx),
        .tail_idx (tail_idx),
        .full     (full),
        .empty    (empty)
    );

    rob_entry_array #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_arr (
        .clk           (clk),
        .rst           (rst),
        .flush         (flush_out),
        .alloc_en      (alloc_gnt),
        .alloc_idx     (tail_idx),
        .alloc_dst_vld (alloc_dst_vld),
        .alloc_dst_reg (alloc_dst_reg),
        .cmpl_en       (cmpl_vld),
        .cmpl_idx      (cmpl_idx),
        .cmpl_fault    (cmpl_fault),
        .free_en       (retire_vld),
        .free_idx      (head_idx),
        .ent_o         (ents)
    );

    rob_restore_timer #(.RESTORE_CYC(RESTORE_CYC)) u_rst_tmr (
        .clk   (clk),
        .rst   (rst),
        .start (flush_out),
        .busy  (restore_busy)
    );
endmodule

// File: rtl/rob_commit_queue_chk.sv
module rob_commit_queue_chk #(
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             alloc_gnt,
    input logic [IDX_W-1:0] alloc_idx,
    input logic             retire_vld,
    input logic [IDX_W-1:0] retire_idx,
    input logic             retire_wr,
    input logic             flush_out,
    input logic             restore_busy,
    input logic             full,
    input logic             empty
);
    AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (empty && !full && !restore_busy)); // R1

    AST_ALLOC_STEP: assert property (@(posedge clk) disable iff (rst)
        ($past(alloc_gnt) && !$past(flush_out) && !$past(rst)) |->
            alloc_idx == IDX_W'($past(alloc_idx) + 1'b1)); // R2

    AST_NO_GNT_FULL: assert property (@(posedge clk) disable iff (rst)
        full |-> !alloc_gnt); // R3

    AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(full && empty)); // R3

    AST_RETIRE_ORDER: assert property (@(posedge clk) disable iff (rst)
        (retire_vld && $past(retire_vld) && !$past(rst)) |->
            retire_idx == IDX_W'($past(retire_idx) + 1'b1)); // R5

    AST_WR_WITH_RETIRE: assert property (@(posedge clk) disable iff (rst)
        retire_wr |-> retire_vld); // R5

    AST_RETIRE_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
        retire_vld |-> !empty); // R6

    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (rst)
        flush_out |=> (empty && alloc_idx == '0)); // R9

    AST_FLUSH_BUSY: assert property (@(posedge clk) disable iff (rst)
        flush_out |=> restore_busy); // R10

    AST_BUSY_NO_GNT: assert property (@(posedge clk) disable iff (rst)
        restore_busy |-> !alloc_gnt); // R10

    AST_NO_RETIRE_FLUSH: assert property (@(posedge clk) disable iff (rst)
        flush_out |-> !retire_vld); // R11
endmodule

bind rob_commit_queue rob_commit_queue_chk #(.IDX_W(IDX_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .alloc_gnt    (alloc_gnt),
    .alloc_idx    (alloc_idx),
    .retire_vld   (retire_vld),
    .retire_idx   (retire_idx),
    .retire_wr    (retire_wr),
    .flush_out    (flush_out),
    .restore_busy (restore_busy),
    .full         (full),
    .empty        (empty)
);

// File: tb/sim_rob_commit_queue.sv
module sim_rob_commit_queue;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       alloc_req = 1'b0, alloc_dst_vld = 1'b0;
    logic [4:0] alloc_dst_reg = '0;
    logic       alloc_gnt;
    logic [2:0] alloc_idx;
    logic       cmpl_vld = 1'b0, cmpl_fault = 1'b0;
    logic [2:0] cmpl_idx = '0;
    logic       retire_vld, retire_wr, flush_out, restore_busy, full, empty;
    logic [2:0] retire_idx;
    logic [4:0] retire_dst_reg;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    rob_commit_queue #(.ENTRIES(8), .RESTORE_CYC(3)) u0 (
        .clk(clk), .rst(rst),
        .alloc_req(alloc_req), .alloc_dst_vld(alloc_dst_vld), .alloc_dst_reg(alloc_dst_reg),
        .alloc_gnt(alloc_gnt), .alloc_idx(alloc_idx),
        .cmpl_vld(cmpl_vld), .cmpl_idx(cmpl_idx), .cmpl_fault(cmpl_fault),
        .retire_vld(retire_vld), .retire_idx(retire_idx), .retire_wr(retire_wr),
        .retire_dst_reg(retire_dst_reg), .flush_out(flush_out),
        .restore_busy(restore_busy), .full(full), .empty(empty)
    );

    typedef struct packed {
        logic       a_req;
        logic       a_dv;
        logic [4:0] a_reg;
        logic       c_vld;
        logic [2:0] c_idx;
        logic       c_flt;
        logic       e_gnt;
        logic [2:0] e_aidx;
        logic       e_ret;
        logic [2:0] e_ridx;
        logic       e_wr;
        logic [4:0] e_rreg;
        logic       e_empty;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b1,5'd1,  1'b0,3'd0,1'b0, 1'b1,3'd0, 1'b0,3'd0,1'b0,5'd0,  1'b1},
        '{1'b1,1'b1,5'd11, 1'b0,3'd0,1'b0, 1'b1,3'd1, 1'b0,3'd0,1'b0,5'd0,  1'b0},
        '{1'b1,1'b0,5'd0,  1'b1,3'd1,1'b0, 1'b1,3'd2, 1'b0,3'd0,1'b0,5'd0,  1'b0},
        '{1'b0,1'b0,5'd0,  1'b1,3'd2,1'b0, 1'b0,3'd3, 1'b0,3'd0,1'b0,5'd0,  1'b0},
        '{1'b0,1'b0,5'd0,  1'b1,3'd0,1'b0, 1'b0,3'd3, 1'b0,3'd0,1'b0,5'd0,  1'b0},
        '{1'b0,1'b0,5'd0,  1'b0,3'd0,1'b0, 1'b0,3'd3, 1'b1,3'd0,1'b1,5'd1,  1'b0},
        '{1'b0,1'b0,5'd0,  1'b0,3'd0,1'b0, 1'b0,3'd3, 1'b1,3'd1,1'b1,5'd11, 1'b0},
        '{1'b0,1'b0,5'd0,  1'b0,3'd0,1'b0, 1'b0,3'd3, 1'b1,3'd2,1'b0,5'd0,  1'b0},
        '{1'b1,1'b1,5'd5,  1'b0,3'd0,1'b0, 1'b1,3'd3, 1'b0,3'd0,1'b0,5'd0,  1'b1},
        '{1'b1,1'b1,5'd7,  1'b1,3'd3,1'b0, 1'b1,3'd4, 1'b0,3'd0,1'b0,5'd0,  1'b0},
        '{1'b0,1'b0,5'd0,  1'b1,3'd4,1'b0, 1'b0,3'd5, 1'b1,3'd3,1'b1,5'd5,  1'b0},
        '{1'b1,1'b1,5'd12, 1'b0,3'd0,1'b0, 1'b1,3'd5, 1'b1,3'd4,1'b1,5'd7,  1'b0},
        '{1'b0,1'b0,5'd0,  1'b1,3'd5,1'b0, 1'b0,3'd6, 1'b0,3'd0,1'b0,5'd0,  1'b0},
        '{1'b0,1'b0,5'd0,  1'b0,3'd0,1'b0, 1'b0,3'd6, 1'b1,3'd5,1'b1,5'd12, 1'b0},
        '{1'b0,1'b0,5'd0,  1'b0,3'd0,1'b0, 1'b0,3'd6, 1'b0,3'd0,1'b0,5'd0,  1'b1}
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic ar, input logic dv, input logic [4:0] rg,
                         input logic cv, input logic [2:0] ci, input logic cf);
        @(negedge clk);
        alloc_req = ar; alloc_dst_vld = dv; alloc_dst_reg = rg;
        cmpl_vld = cv; cmpl_idx = ci; cmpl_fault = cf;
        #1;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        // R1 reset state (reset still held)
        chk("R1", "empty", int'(empty), 1);
        chk("R1", "full", int'(full), 0);
        chk("R1", "retire_vld", int'(retire_vld), 0);
        chk("R1", "flush_out", int'(flush_out), 0);
        chk("R1", "restore_busy", int'(restore_busy), 0);
        rst = 1'b0;

        // table: R2 R4 R5 R6 ordering, write strobe, wrap-free sequence
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].a_req, VECS[i].a_dv, VECS[i].a_reg,
                  VECS[i].c_vld, VECS[i].c_idx, VECS[i].c_flt);
            chk("R2", "alloc_gnt", int'(alloc_gnt), int'(VECS[i].e_gnt));
            chk("R2", "alloc_idx", int'(alloc_idx), int'(VECS[i].e_aidx));
            chk("R5", "retire_vld", int'(retire_vld), int'(VECS[i].e_ret));
            if (VECS[i].e_ret) begin
                chk("R5", "retire_idx", int'(retire_idx), int'(VECS[i].e_ridx));
                chk("R5", "retire_wr", int'(retire_wr), int'(VECS[i].e_wr));
                if (VECS[i].e_wr)
                    chk("R5", "retire_dst_reg", int'(retire_dst_reg), int'(VECS[i].e_rreg));
            end
            chk("R6", "empty", int'(empty), int'(VECS[i].e_empty));
        end

        // R7: completion aimed at free slot 6 is ignored
        drive(1'b0, 1'b0, 5'd0, 1'b1, 3'd6, 1'b0);
        drive(1'b1, 1'b1, 5'd9, 1'b0, 3'd0, 1'b0);
        chk("R2", "alloc_gnt", int'(alloc_gnt), 1);
        chk("R2", "alloc_idx", int'(alloc_idx), 6);
        drive(1'b0, 1'b0, 5'd0, 1'b0, 3'd0, 1'b0);
        chk("R7", "retire_vld after stray completion", int'(retire_vld), 0);

        // R3: fill the remaining seven slots, wrapping the index
        for (int k = 0; k < 7; k++) begin
            drive(1'b1, 1'b1, 5'(20 + k), 1'b0, 3'd0, 1'b0);
            chk("R3", "alloc_gnt fill", int'(alloc_gnt), 1);
            chk("R3", "alloc_idx fill", int'(alloc_idx), (7 + k) % 8);
        end
        drive(1'b1, 1'b1, 5'd31, 1'b0, 3'd0, 1'b0);
        chk("R3", "full", int'(full), 1);
        chk("R3", "alloc_gnt when full", int'(alloc_gnt), 0);
        drive(1'b0, 1'b0, 5'd0, 1'b0, 3'd0, 1'b0);
        chk("R3", "full held", int'(full), 1);
        chk("R3", "tail unchanged", int'(alloc_idx), 6);

        // R4: younger slot 7 finishes first, head 6 still pending
        drive(1'b0, 1'b0, 5'd0, 1'b1, 3'd7, 1'b0);
        drive(1'b0, 1'b0, 5'd0, 1'b0, 3'd0, 1'b0);
        chk("R4", "no retire past pending head", int'(retire_vld), 0);

        // head 6 finishes
        drive(1'b0, 1'b0, 5'd0, 1'b1, 3'd6, 1'b0);
        drive(1'b0, 1'b0, 5'd0, 1'b0, 3'd0, 1'b0);
        chk("R5", "retire_vld head6", int'(retire_vld), 1);
        chk("R5", "retire_idx head6", int'(retire_idx), 6);
        chk("R5", "retire_dst_reg head6", int'(retire_dst_reg), 9);

        // R8: grant, completion of slot 0 and retirement of slot 7 together
        drive(1'b1, 1'b1, 5'd30, 1'b1, 3'd0, 1'b0);
        chk("R8", "retire_vld", int'(retire_vld), 1);
        chk("R8", "retire_idx", int'(retire_idx), 7);
        chk("R8", "retire_dst_reg", int'(retire_dst_reg), 20);
        chk("R8", "alloc_gnt", int'(alloc_gnt), 1);
        chk("R8", "alloc_idx", int'(alloc_idx), 6);
        drive(1'b0, 1'b0, 5'd0, 1'b0, 3'd0, 1'b0);
        chk("R8", "retire slot0", int'(retire_idx), 0);
        chk("R8", "retire_dst_reg slot0", int'(retire_dst_reg), 21);

        // R9/R11: younger slot 2 finishes cleanly, head slot 1 faults
        drive(1'b0, 1'b0, 5'd0, 1'b1, 3'd2, 1'b0);
        drive(1'b0, 1'b0, 5'd0, 1'b1, 3'd1, 1'b1);
        drive(1'b1, 1'b1, 5'd3, 1'b0, 3'd0, 1'b0);
        chk("R9", "flush_out", int'(flush_out), 1);
        chk("R9", "retire_vld during fault", int'(retire_vld), 0);
        chk("R9", "alloc_gnt during fault", int'(alloc_gnt), 0);
        for (int c = 0; c < 3; c++) begin
            drive(1'b1, 1'b1, 5'd3, 1'b0, 3'd0, 1'b0);
            chk("R9", "empty after flush", int'(empty), 1);
            chk("R9", "alloc_idx reset", int'(alloc_idx), 0);
            chk("R10", "restore_busy", int'(restore_busy), 1);
            chk("R10", "alloc_gnt while busy", int'(alloc_gnt), 0);
            chk("R11", "no retire of flushed slot", int'(retire_vld), 0);
        end
        drive(1'b1, 1'b1, 5'd3, 1'b0, 3'd0, 1'b0);
        chk("R10", "restore_busy ends", int'(restore_busy), 0);
        chk("R10", "alloc_gnt after restore", int'(alloc_gnt), 1);
        chk("R10", "alloc_idx after restore", int'(alloc_idx), 0);
        drive(1'b0, 1'b0, 5'd0, 1'b0, 3'd0, 1'b0);
        chk("R11", "retire_vld new slot pending", int'(retire_vld), 0);
        chk("R6", "empty after new alloc", int'(empty), 0);

        finish_run();
    end
endmodule